// File: doc/BRIEF.md
# Buck Converter Fault Protection Sequencer

This block is the protection state machine of a single-phase synchronous buck controller. Analog comparators outside the block report, as single bits, whether the output is over its overvoltage limit, whether it has fallen under half of the reference, whether it is under the undervoltage limit, and whether the inductor sense voltage is over the lower or the upper overcurrent limit. The block samples these bits once per switching cycle, on a one-clock cycle tick. From them it drives override controls for the high-side and low-side gates and an enable for a bleed resistor from the switch node to ground.

A fault latches and stays latched until the controller is disabled or its supply drops, which the block sees as its supply-good input going low. An overvoltage first clamps the low-side gate on. Once the output has fallen under half of the reference, the clamp is released and the bleed path discharges the rest. An undervoltage or overcurrent fault turns both gates off. While the supply is good but the controller is disabled, a separate comparator bit can clamp the low-side gate on to protect the load. This clamp does nothing once the controller is enabled.

Top module: `buck_fault_guard`

## Requirements
- R1: After synchronous reset, `hs_off`=1, `ls_off`=1, `ls_on`=0, `bleed_en`=0 and all three fault flags are 0. The first clock edge at which `en` and `uvlo_ok` are both high takes the block to the running state, in which all four drive outputs are 0.
- R2: A tick with `cmp_ov`=1 in the running state latches `flt_ov` and gives `hs_off`=1, `ls_on`=1, `ls_off`=0, `bleed_en`=0. This holds whatever the value of `ss_done`.
- R3: In the overvoltage clamp, a tick with `cmp_half`=1 (output under half of the reference) moves the block to the bleed phase: `hs_off`=1, `ls_off`=1, `ls_on`=0, `bleed_en`=1, with `flt_ov` still set.
- R4: A tick with `cmp_uv`=1 and `ss_done`=1 in the running state latches `flt_uv` with `hs_off`=`ls_off`=1. With `ss_done`=0, `cmp_uv` is ignored.
- R5: `cmp_oc1` high on `OC_HITS` (default 4) consecutive ticks latches `flt_oc` with both gates off. Any tick with `cmp_oc1`=0 resets the run count to zero. Cycles without a tick do not count.
- R6: A tick with `cmp_oc2`=1 latches `flt_oc` at once, with both gates off.
- R7: Only one fault flag is ever set. When faults arrive on the same tick, overvoltage wins over overcurrent, and overcurrent wins over undervoltage.
- R8: A latched fault and its drive pattern stay fixed while `en` and `uvlo_ok` stay high, even after every comparator returns to 0.
- R9: `en`=0 or `uvlo_ok`=0 for one clock clears all fault flags and the overcurrent count and returns the outputs to the reset pattern. Enabling again then returns to the running state.
- R10: With `uvlo_ok`=1, `en`=0 and `cmp_preov`=1, the block gives `ls_on`=1, `ls_off`=0, `hs_off`=1. With `en`=1 or `uvlo_ok`=0, `cmp_preov` has no effect.
- R11: While enabled, comparator bits on a clock without `cycle_tick` change nothing. Every output is registered and reflects the inputs of the edge before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_tick | input | 1 | One-clock strobe, once per switching cycle |
| en | input | 1 | Controller enable |
| uvlo_ok | input | 1 | Supplies above their lockout thresholds |
| ss_done | input | 1 | Soft-start finished |
| cmp_ov | input | 1 | Output above overvoltage limit |
| cmp_half | input | 1 | Output below half of the reference |
| cmp_uv | input | 1 | Output below undervoltage limit |
| cmp_oc1 | input | 1 | Sense voltage above lower overcurrent limit |
| cmp_oc2 | input | 1 | Sense voltage above upper overcurrent limit |
| cmp_preov | input | 1 | Output above pre-enable clamp threshold |
| hs_off | output | 1 | Force high-side gate off |
| ls_off | output | 1 | Force low-side gate off |
| ls_on | output | 1 | Force low-side gate on |
| bleed_en | output | 1 | Connect bleed resistor |
| flt_ov | output | 1 | Latched overvoltage fault |
| flt_uv | output | 1 | Latched undervoltage fault |
| flt_oc | output | 1 | Latched overcurrent fault (either level) |

## Verification
The properties assume that `en`, `uvlo_ok` and the comparator bits are already synchronous to `clk` and change only between edges, and that `cycle_tick` is a single-cycle strobe. They make no assumption about the order of comparator bits, so combinations that cannot occur physically, such as `cmp_ov` together with `cmp_half`, are still legal. The stimulus drives every input on the falling edge. The tick fires on about one clock in four. The enable and supply-good inputs drop only rarely, so that latched states last long enough to be observed. The comparators use biased probabilities so that overcurrent runs of four and same-tick fault collisions both occur.

// File: rtl/fault_guard_pkg.sv
`timescale 1ns/1ps
package fault_guard_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUN,
    ST_OV_CLAMP,
    ST_OV_BLEED,
    ST_SHUT
  } guard_state_e;

  // fault flag vector order {oc, uv, ov}
  localparam int FLT_W = 3;
  localparam logic [FLT_W-1:0] FLT_NONE = 3'b000;
  localparam logic [FLT_W-1:0] FLT_OV   = 3'b001;
  localparam logic [FLT_W-1:0] FLT_UV   = 3'b010;
  localparam logic [FLT_W-1:0] FLT_OC   = 3'b100;

  typedef struct packed {
    logic hs_off;
    logic ls_off;
    logic ls_on;
    logic bleed;
  } drive_t;
endpackage

// File: rtl/fg_oc_filter.sv
`timescale 1ns/1ps
module fg_oc_filter #(
  parameter int OC_HITS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic tick,
  input  logic oc1,
  input  logic oc2,
  output logic trip
);
  localparam int CW = $clog2(OC_HITS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(OC_HITS);

  logic [CW-1:0] run_q, run_n;

  always_comb begin
    run_n = run_q;
    if (!active)
      run_n = '0;
    else if (tick) begin
      if (!oc1)
        run_n = '0;
      else if (run_q != CNT_MAX)
        run_n = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= run_n;
  end

  assign trip = active && tick && (oc2 || (oc1 && run_n == CNT_MAX));
endmodule

// File: rtl/fg_state_core.sv
`timescale 1ns/1ps
module fg_state_core
  import fault_guard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 active,
  input  logic                 tick,
  input  logic                 ov,
  input  logic                 half,
  input  logic                 uv,
  input  logic                 ss_done,
  input  logic                 oc_trip,
  output guard_state_e         state_n,
  output logic [FLT_W-1:0]     flt_n
);
  guard_state_e        state_q, cur;
  logic [FLT_W-1:0]    flt_q;

  always_comb begin
    cur     = (state_q == ST_IDLE) ? ST_RUN : state_q;
    state_n = state_q;
    flt_n   = flt_q;
    if (!active) begin
      state_n = ST_IDLE;
      flt_n   = FLT_NONE;
    end else begin
      state_n = cur;
      if (tick) begin
        case (cur)
          ST_RUN: begin
            if (ov) begin
              state_n = ST_OV_CLAMP;
              flt_n   = FLT_OV;
            end else if (oc_trip) begin
              state_n = ST_SHUT;
              flt_n   = FLT_OC;
            end else if (uv && ss_done) begin
              state_n = ST_SHUT;
              flt_n   = FLT_UV;
            end
          end
          ST_OV_CLAMP: if (half) state_n = ST_OV_BLEED;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      flt_q   <= FLT_NONE;
    end else begin
      state_q <= state_n;
      flt_q   <= flt_n;
    end
  end
endmodule

// File: rtl/fg_drive_map.sv
`timescale 1ns/1ps
module fg_drive_map
  import fault_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  guard_state_e     state_n,
  input  logic [FLT_W-1:0] flt_n,
  input  logic             en,
  input  logic             uvlo_ok,
  input  logic             preov,
  output drive_t           drv_q,
  output logic [FLT_W-1:0] flt_q
);
  drive_t drv_n;
  logic   clamp;

  assign clamp = uvlo_ok && !en && preov;

  always_comb begin
    drv_n = '{hs_off: 1'b1, ls_off: 1'b1, ls_on: 1'b0, bleed: 1'b0};
    case (state_n)
      ST_IDLE: if (clamp) begin
        drv_n.ls_off = 1'b0;
        drv_n.ls_on  = 1'b1;
      end
      ST_RUN:      drv_n = '0;
      ST_OV_CLAMP: begin
        drv_n.ls_off = 1'b0;
        drv_n.ls_on  = 1'b1;
      end
      ST_OV_BLEED: drv_n.bleed = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_q <= '{hs_off: 1'b1, ls_off: 1'b1, ls_on: 1'b0, bleed: 1'b0};
      flt_q <= FLT_NONE;
    end else begin
      drv_q <= drv_n;
      flt_q <= flt_n;
    end
  end
endmodule

// File: rtl/buck_fault_guard.sv
`timescale 1ns/1ps
module buck_fault_guard
  import fault_guard_pkg::*;
#(
  parameter int OC_HITS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cycle_tick,
  input  logic en,
  input  logic uvlo_ok,
  input  logic ss_done,
  input  logic cmp_ov,
  input  logic cmp_half,
  input  logic cmp_uv,
  input  logic cmp_oc1,
  input  logic cmp_oc2,
  input  logic cmp_preov,
  output logic hs_off,
  output logic ls_off,
  output logic ls_on,
  output logic bleed_en,
  output logic flt_ov,
  output logic flt_uv,
  output logic flt_oc
);
  logic             active, oc_trip;
  guard_state_e     state_n;
  logic [FLT_W-1:0] flt_n, flt_q;
  drive_t           drv_q;

  assign active = en && uvlo_ok;

  fg_oc_filter #(.OC_HITS(OC_HITS)) u_ocf (
    .clk(clk), .rst(rst), .active(active), .tick(cycle_tick),
    .oc1(cmp_oc1), .oc2(cmp_oc2), .trip(oc_trip)
  );

  fg_state_core u_core (
    .clk(clk), .rst(rst), .active(active), .tick(cycle_tick),
    .ov(cmp_ov), .half(cmp_half), .uv(cmp_uv), .ss_done(ss_done),
    .oc_trip(oc_trip), .state_n(state_n), .flt_n(flt_n)
  );

  fg_drive_map u_map (
    .clk(clk), .rst(rst), .state_n(state_n), .flt_n(flt_n),
    .en(en), .uvlo_ok(uvlo_ok), .preov(cmp_preov),
    .drv_q(drv_q), .flt_q(flt_q)
  );

  assign hs_off   = drv_q.hs_off;
  assign ls_off   = drv_q.ls_off;
  assign ls_on    = drv_q.ls_on;
  assign bleed_en = drv_q.bleed;
  assign flt_ov   = flt_q[0];
  assign flt_uv   = flt_q[1];
  assign flt_oc   = flt_q[2];
endmodule

// File: rtl/fg_guard_checker.sv
`timescale 1ns/1ps
module fg_guard_checker (
  input logic clk,
  input logic rst,
  input logic cycle_tick,
  input logic en,
  input logic uvlo_ok,
  input logic cmp_ov,
  input logic cmp_oc2,
  input logic cmp_preov,
  input logic hs_off,
  input logic ls_off,
  input logic ls_on,
  input logic bleed_en,
  input logic flt_ov,
  input logic flt_uv,
  input logic flt_oc
);
  assert_ov_trip_R2: assert property (@(posedge clk) disable iff (rst)
    cycle_tick && en && uvlo_ok && cmp_ov && !flt_uv && !flt_oc |=> flt_ov);

  assert_bleed_phase_R3: assert property (@(posedge clk) disable iff (rst)
    bleed_en |-> flt_ov && hs_off && ls_off && !ls_on);

  assert_oc_fast_R6: assert property (@(posedge clk) disable iff (rst)
    cycle_tick && en && uvlo_ok && cmp_oc2 |=> flt_oc || flt_ov || flt_uv);

  assert_single_fault_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flt_ov, flt_uv, flt_oc}));

  assert_latch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (flt_ov || flt_uv || flt_oc) && en && uvlo_ok |=>
      $stable({flt_ov, flt_uv, flt_oc}));

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    !en || !uvlo_ok |=> !flt_ov && !flt_uv && !flt_oc && !bleed_en);

  assert_preclamp_R10: assert property (@(posedge clk) disable iff (rst)
    uvlo_ok && !en && cmp_preov |=> ls_on && !ls_off && hs_off);
endmodule

bind buck_fault_guard fg_guard_checker u_guard_chk (
  .clk(clk), .rst(rst), .cycle_tick(cycle_tick), .en(en), .uvlo_ok(uvlo_ok),
  .cmp_ov(cmp_ov), .cmp_oc2(cmp_oc2), .cmp_preov(cmp_preov),
  .hs_off(hs_off), .ls_off(ls_off), .ls_on(ls_on), .bleed_en(bleed_en),
  .flt_ov(flt_ov), .flt_uv(flt_uv), .flt_oc(flt_oc)
);

// File: tb/buck_fault_guard_test.sv
`timescale 1ns/1ps
module buck_fault_guard_test;
  localparam int HITS = 4;
  // packed output order {hs_off, ls_off, ls_on, bleed, oc, uv, ov}
  localparam logic [6:0] P_IDLE  = 7'b1100_000;
  localparam logic [6:0] P_CLAMP = 7'b1010_000;
  localparam logic [6:0] P_RUN   = 7'b0000_000;
  localparam logic [6:0] P_OVC   = 7'b1010_001;
  localparam logic [6:0] P_OVB   = 7'b1101_001;
  localparam logic [6:0] P_UV    = 7'b1100_010;
  localparam logic [6:0] P_OC    = 7'b1100_100;

  logic clk = 0, rst = 1;
  logic cycle_tick = 0, en = 0, uvlo_ok = 0, ss_done = 0;
  logic cmp_ov = 0, cmp_half = 0, cmp_uv = 0, cmp_oc1 = 0, cmp_oc2 = 0, cmp_preov = 0;
  logic hs_off, ls_off, ls_on, bleed_en, flt_ov, flt_uv, flt_oc;
  int checks = 0, errors = 0;

  // reference model: 0 idle, 1 run, 2 ov clamp, 3 ov bleed, 4 shut
  int m_st = 0, m_cnt = 0;
  logic [2:0] m_flt = 3'b000;   // {oc, uv, ov}

  always #2 clk = ~clk;

  buck_fault_guard #(.OC_HITS(HITS)) uut (.*);

  function automatic logic [6:0] expect_out();
    logic cl;
    cl = uvlo_ok && !en && cmp_preov;
    case (m_st)
      0: return cl ? {4'b1010, m_flt} : {4'b1100, m_flt};
      1: return {4'b0000, m_flt};
      2: return {4'b1010, m_flt};
      3: return {4'b1101, m_flt};
      default: return {4'b1100, m_flt};
    endcase
  endfunction

  function automatic void model_step();
    int s;
    if (!(en && uvlo_ok)) begin
      m_st = 0; m_flt = 3'b000; m_cnt = 0;
    end else begin
      s = (m_st == 0) ? 1 : m_st;
      if (cycle_tick) begin
        m_cnt = cmp_oc1 ? ((m_cnt < HITS) ? m_cnt + 1 : HITS) : 0;
        if (s == 1) begin
          if (cmp_ov) begin s = 2; m_flt = 3'b001; end
          else if (cmp_oc2 || (cmp_oc1 && m_cnt == HITS)) begin s = 4; m_flt = 3'b100; end
          else if (cmp_uv && ss_done) begin s = 4; m_flt = 3'b010; end
        end else if (s == 2 && cmp_half) s = 3;
      end
      m_st = s;
    end
  endfunction

  function automatic void chk(string req, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", req, act, exp);
    end
  endfunction

  function automatic logic [6:0] outs();
    return {hs_off, ls_off, ls_on, bleed_en, flt_oc, flt_uv, flt_ov};
  endfunction

  // one clock: inputs set before the call at negedge, model updated, sampled after edge
  task automatic step();
    model_step();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic t, input logic e, input logic u, input logic ss,
                       input logic ov, input logic hf, input logic uv,
                       input logic o1, input logic o2, input logic pre);
    @(negedge clk);
    cycle_tick = t; en = e; uvlo_ok = u; ss_done = ss;
    cmp_ov = ov; cmp_half = hf; cmp_uv = uv; cmp_oc1 = o1; cmp_oc2 = o2; cmp_preov = pre;
    step();
  endtask

  task automatic toggle_en();
    drive(0,0,1,1,0,0,0,0,0,0);
    drive(0,1,1,1,0,0,0,0,0,0);
  endtask

  initial begin
    #(4 * 190000);
    errors++; checks++;
    $display("FAIL watchdog: outputs timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #0 chk("R1 reset", outs(), P_IDLE);
    drive(0,1,1,1,0,0,0,0,0,0); chk("R1 run", outs(), P_RUN);
    // R2 overvoltage during soft-start
    drive(1,1,1,0,1,0,0,0,0,0); chk("R2", outs(), P_OVC);
    // R11 half bit without tick ignored
    drive(0,1,1,1,0,1,0,0,0,0); chk("R11", outs(), P_OVC);
    drive(1,1,1,1,0,1,0,0,0,0); chk("R3", outs(), P_OVB);
    drive(1,1,1,1,0,0,0,0,0,0); chk("R8 bleed held", outs(), P_OVB);
    drive(0,0,1,1,0,0,0,0,0,0); chk("R9 en clear", outs(), P_IDLE);
    drive(0,1,1,1,0,0,0,0,0,0); chk("R9 rerun", outs(), P_RUN);
    drive(1,1,1,0,0,0,1,0,0,0); chk("R4 uv before ss", outs(), P_RUN);
    drive(1,1,1,1,0,0,1,0,0,0); chk("R4 uv", outs(), P_UV);
    drive(1,1,1,1,0,0,0,0,0,0); chk("R8 uv held", outs(), P_UV);
    drive(0,1,0,1,0,0,0,0,0,0); chk("R9 uvlo clear", outs(), P_IDLE);
    drive(0,1,1,1,0,0,0,0,0,0); chk("R9 uvlo rerun", outs(), P_RUN);
    // R5: three ticks, break, then four with idle clocks between
    for (int i = 0; i < 3; i++) begin
      drive(1,1,1,1,0,0,0,1,0,0); drive(0,1,1,1,0,0,0,1,0,0);
    end
    drive(1,1,1,1,0,0,0,0,0,0); chk("R5 break", outs(), P_RUN);
    for (int i = 0; i < 3; i++) begin
      drive(1,1,1,1,0,0,0,1,0,0); drive(0,1,1,1,0,0,0,1,0,0);
      drive(0,1,1,1,0,0,0,1,0,0);
    end
    chk("R5 three hits", outs(), P_RUN);
    drive(1,1,1,1,0,0,0,1,0,0); chk("R5 fourth hit", outs(), P_OC);
    toggle_en();
    drive(0,1,1,1,0,0,0,0,1,0); chk("R11 oc2 no tick", outs(), P_RUN);
    drive(1,1,1,1,0,0,0,1,1,0); chk("R6", outs(), P_OC);
    toggle_en();
    drive(1,1,1,1,1,0,1,1,1,0); chk("R7 ov first", outs(), P_OVC);
    toggle_en();
    drive(1,1,1,1,0,0,1,1,1,0); chk("R7 oc over uv", outs(), P_OC);
    drive(0,0,1,1,0,0,0,0,0,1); chk("R10 clamp", outs(), P_CLAMP);
    drive(0,1,1,1,0,0,0,0,0,1); chk("R10 enabled", outs(), P_RUN);
    drive(0,0,0,1,0,0,0,0,0,1); chk("R10 no supply", outs(), P_IDLE);

    // constrained random run against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cycle_tick = ($urandom_range(3) == 0);
      en         = ($urandom_range(60) != 0);
      uvlo_ok    = ($urandom_range(80) != 0);
      ss_done    = ($urandom_range(9) != 0);
      cmp_ov     = ($urandom_range(40) == 0);
      cmp_half   = ($urandom_range(3) == 0);
      cmp_uv     = ($urandom_range(25) == 0);
      cmp_oc1    = ($urandom_range(9) < 7);
      cmp_oc2    = ($urandom_range(50) == 0);
      cmp_preov  = ($urandom_range(1) == 0);
      step();
      chk("random R8/R11", outs(), expect_out());
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule